// File: doc/BRIEF.md
# CAS-before-RAS Refresh Burst Engine

This block keeps a DRAM alive by issuing bursts of CAS-before-RAS refresh cycles. The memory advances its own internal row counter on every such cycle, so the engine drives only the two active-low strobes and never touches the address bus. Each refresh cycle lowers the column strobe first, then the row strobe, then raises the column strobe, then the row strobe. Successive cycles are separated by a precharge gap during which both strobes stay high.

Refresh work arrives as requests. A built-in interval timer raises one every `INTERVAL` clocks while enabled, and a one-cycle `force_req` input adds one on demand. A single pending flag holds the request until the sequencer is idle. The burst length is taken from `burst_len` when the burst starts, and a value of zero stands for 256 cycles. As an example, a device that needs 512 rows refreshed within 8 ms is served by bursts of 8 issued every 125 µs (6250 clocks at 50 MHz, the default). Two back-to-back 256-cycle bursts also sweep such a device once. Arbitration against normal accesses belongs to the surrounding controller, which watches `busy` and `done`.

Top module: `cbr_refresh_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ras_n` and `cas_n` are 1, and `busy`, `done` and `refresh_due` are 0.
- R2: Within each refresh cycle the strobes go through {ras_n,cas_n} = 10 for LEAD_CYC clocks, then 00 for BOTH_CYC clocks, then 01 for TAIL_CYC clocks. The row strobe therefore only falls while the column strobe is already low, and the column strobe only rises while the row strobe is still low.
- R3: Every refresh cycle, including the last one of a burst, ends with PRE_CYC clocks of {ras_n,cas_n} = 11 before the next cycle may begin.
- R4: A burst runs exactly `burst_len` refresh cycles for values 1 to 2^CNT_W−1, and 2^CNT_W cycles for the value 0. The value is captured in the clock edge that starts the burst, and later changes have no effect on that burst.
- R5: With `timer_en` high, the timer raises a refresh request once every INTERVAL clocks. Taking `timer_en` low clears the timer and stops further requests.
- R6: A request, whether from `force_req` or the timer, sets `refresh_due` at the next clock edge. If the sequencer is idle, the edge after that starts the burst (cas_n goes low) and clears `refresh_due`. Any number of requests that arrive while a burst runs collapse into exactly one further burst.
- R7: `busy` is 1 from the first cycle of a burst through its last precharge clock. `done` is a single-cycle pulse in the first clock after that.
- R8: When no burst is running, both strobes are held high whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_en | input | 1 | Enables the interval timer; low clears it |
| force_req | input | 1 | One-clock request for a burst |
| burst_len | input | CNT_W | Refresh cycles per burst, 0 means 2^CNT_W |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-clock pulse after a burst ends |
| refresh_due | output | 1 | A request is pending |

## Verification
The engine is driven with single forced requests at burst lengths of 1, 5, 255-class values and 0. These patterns separate correct counting from off-by-one errors and from a zero that is mistaken for no cycles. A burst whose length input changes part way through shows whether the length is captured once. Several forced requests issued during one burst must yield exactly one further burst, which distinguishes a pending flag from a counter or a lost request. Timer runs with short bursts measure the start-to-start period. Timer runs with 256-cycle bursts, which are longer than the period, exercise back-to-back bursts started from a flag that was latched while the engine was busy.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_BOTH = 3'd2,
    PH_TAIL = 3'd3,
    PH_PRE  = 3'd4
  } phase_t;

  // {ras_n, cas_n} driven in each phase
  function automatic logic [1:0] strobe_pair(input phase_t ph);
    case (ph)
      PH_LEAD: strobe_pair = 2'b10;
      PH_BOTH: strobe_pair = 2'b00;
      PH_TAIL: strobe_pair = 2'b01;
      default: strobe_pair = 2'b11;
    endcase
  endfunction

  // Phase order within one refresh cycle
  function automatic phase_t next_phase(input phase_t ph);
    case (ph)
      PH_LEAD: next_phase = PH_BOTH;
      PH_BOTH: next_phase = PH_TAIL;
      PH_TAIL: next_phase = PH_PRE;
      default: next_phase = PH_LEAD;
    endcase
  endfunction

  // Loaded count to number of refresh cycles; zero wraps to 2^w
  function automatic int unsigned cycles_in_burst(input int unsigned len,
                                                  input int unsigned w);
    cycles_in_burst = (len == 0) ? (32'd1 << w) : len;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max4 = m;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int unsigned INTERVAL = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt;
  logic at_last;

  assign at_last = (cnt == LAST);
  assign tick    = en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || at_last)   cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  generate
    if (INTERVAL > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    end
  endgenerate

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R5

endmodule

// File: rtl/cbr_req_latch.sv
module cbr_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic req,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !take) || due || req;
  end

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend); // R6

  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(due || req)); // R6

endmodule

// File: rtl/cbr_cycle_seq.sv
module cbr_cycle_seq
  import cbr_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned BOTH_CYC = 2,
  parameter int unsigned TAIL_CYC = 1,
  parameter int unsigned PRE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  output logic             ras_n,
  output logic             cas_n,
  output logic             busy,
  output logic             done,
  output logic             idle
);
  localparam int unsigned PMAX  = max4(LEAD_CYC, BOTH_CYC, TAIL_CYC, PRE_CYC);
  localparam int unsigned PC_W  = $clog2(PMAX + 1);
  localparam int unsigned REM_W = CNT_W + 1;

  function automatic int unsigned dwell(input phase_t ph);
    case (ph)
      PH_LEAD: dwell = LEAD_CYC;
      PH_BOTH: dwell = BOTH_CYC;
      PH_TAIL: dwell = TAIL_CYC;
      PH_PRE:  dwell = PRE_CYC;
      default: dwell = 1;
    endcase
  endfunction

  phase_t           ph;
  logic [PC_W-1:0]  pc;
  logic [REM_W-1:0] rem;
  logic             phase_end;
  logic             last_cycle;
  logic             burst_end;

  assign phase_end  = (ph != PH_IDLE) && (pc == PC_W'(dwell(ph) - 1));
  assign last_cycle = (rem == REM_W'(1));
  assign burst_end  = phase_end && (ph == PH_PRE) && last_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      pc   <= '0;
      rem  <= '0;
      done <= 1'b0;
    end else begin
      done <= burst_end;
      if (ph == PH_IDLE) begin
        if (start) begin
          ph  <= PH_LEAD;
          pc  <= '0;
          rem <= REM_W'(cycles_in_burst(32'(burst_len), CNT_W));
        end
      end else if (phase_end) begin
        pc <= '0;
        if (burst_end) begin
          ph <= PH_IDLE;
        end else begin
          ph <= next_phase(ph);
          if (ph == PH_PRE) rem <= rem - 1'b1;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  assign {ras_n, cas_n} = strobe_pair(ph);
  assign busy = (ph != PH_IDLE);
  assign idle = (ph == PH_IDLE);

  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n))); // R2

  AST_CAS_RISE_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n); // R2

  AST_PRECHARGE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R7

  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem != '0)); // R4

endmodule

// File: rtl/cbr_refresh_engine.sv
module cbr_refresh_engine #(
  parameter int unsigned INTERVAL = 6250,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned BOTH_CYC = 2,
  parameter int unsigned TAIL_CYC = 1,
  parameter int unsigned PRE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_en,
  input  logic             force_req,
  input  logic [CNT_W-1:0] burst_len,
  output logic             ras_n,
  output logic             cas_n,
  output logic             busy,
  output logic             done,
  output logic             refresh_due
);
  logic tick;
  logic seq_idle;
  logic take;

  cbr_interval_timer #(.INTERVAL(INTERVAL)) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (timer_en),
    .tick (tick)
  );

  cbr_req_latch latch_i (
    .clk  (clk),
    .rst_n(rst_n),
    .due  (tick),
    .req  (force_req),
    .take (take),
    .pend (refresh_due)
  );

  assign take = refresh_due && seq_idle;

  cbr_cycle_seq #(
    .CNT_W   (CNT_W),
    .LEAD_CYC(LEAD_CYC),
    .BOTH_CYC(BOTH_CYC),
    .TAIL_CYC(TAIL_CYC),
    .PRE_CYC (PRE_CYC)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .burst_len(burst_len),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .busy     (busy),
    .done     (done),
    .idle     (seq_idle)
  );

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(take)) |-> (ras_n && cas_n)); // R8

  AST_START_FROM_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(refresh_due)); // R6

endmodule

// File: tb/cbr_refresh_engine_tb_top.sv
module cbr_refresh_engine_tb_top;
  localparam int unsigned INTERVAL = 300;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned LEAD_CYC = 1;
  localparam int unsigned BOTH_CYC = 2;
  localparam int unsigned TAIL_CYC = 1;
  localparam int unsigned PRE_CYC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timer_en = 1'b0;
  logic force_req = 1'b0;
  logic [CNT_W-1:0] burst_len = 8'd8;
  logic ras_n, cas_n, busy, done, refresh_due;

  always #10 clk = ~clk; // 50 MHz

  cbr_refresh_engine #(
    .INTERVAL(INTERVAL), .CNT_W(CNT_W), .LEAD_CYC(LEAD_CYC),
    .BOTH_CYC(BOTH_CYC), .TAIL_CYC(TAIL_CYC), .PRE_CYC(PRE_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .force_req(force_req),
    .burst_len(burst_len), .ras_n(ras_n), .cas_n(cas_n), .busy(busy),
    .done(done), .refresh_due(refresh_due)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int        m_timer;
  bit        m_pend;
  bit [1:0]  m_q[$];
  bit [1:0]  e_str = 2'b11;
  bit        e_busy = 1'b0;
  bit        e_done = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_timer = 0; m_pend = 0; m_q.delete();
      e_str = 2'b11; e_busy = 0; e_done = 0;
    end else begin
      bit tk, st;
      int n;
      tk = timer_en && (m_timer == INTERVAL - 1);
      m_timer = tk ? 0 : (timer_en ? m_timer + 1 : 0);
      st = m_pend && !e_busy;
      e_done = 0;
      if (st) begin
        n = (burst_len == 0) ? (1 << CNT_W) : int'(burst_len);
        for (int k = 0; k < n; k++) begin
          for (int j = 0; j < LEAD_CYC; j++) m_q.push_back(2'b10);
          for (int j = 0; j < BOTH_CYC; j++) m_q.push_back(2'b00);
          for (int j = 0; j < TAIL_CYC; j++) m_q.push_back(2'b01);
          for (int j = 0; j < PRE_CYC;  j++) m_q.push_back(2'b11);
        end
      end
      if (m_q.size() > 0) begin
        e_str = m_q.pop_front();
        e_busy = 1;
      end else begin
        if (e_busy) e_done = 1;
        e_busy = 0;
        e_str = 2'b11;
      end
      m_pend = (m_pend && !st) || tk || force_req;
    end
  end

  // per-clock comparison plus simple event monitors
  int cyc = 0;
  int ras_falls = 0;
  int done_cnt = 0;
  int busy_rises = 0;
  int last_rise = 0;
  int prev_rise = 0;
  logic prev_ras = 1'b1;
  logic prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      check("R2 R3 R8 ras_n", ras_n, e_str[1]);
      check("R2 R3 R8 cas_n", cas_n, e_str[0]);
      check("R7 busy", busy, e_busy);
      check("R7 done", done, e_done);
      check("R5 R6 refresh_due", refresh_due, m_pend);
      if (prev_ras && !ras_n) ras_falls++;
      if (done) done_cnt++;
      if (!prev_busy && busy) begin
        busy_rises++;
        prev_rise = last_rise;
        last_rise = cyc;
      end
    end
    prev_ras = ras_n;
    prev_busy = busy;
  end

  task automatic pulse_req();
    force_req = 1'b1;
    @(negedge clk);
    force_req = 1'b0;
  endtask

  task automatic wait_quiet();
    int guard = 0;
    while ((busy || refresh_due) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_burst(input int len, input string tag, input int exp_cycles);
    burst_len = CNT_W'(len);
    @(negedge clk);
    ras_falls = 0;
    done_cnt = 0;
    pulse_req();
    wait_quiet();
    check(tag, ras_falls, exp_cycles);
    check("R7 one done per burst", done_cnt, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 ras_n in reset", ras_n, 1);
    check("R1 cas_n in reset", cas_n, 1);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 due in reset", refresh_due, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes after release", {ras_n, cas_n}, 3);
    check("R1 busy after release", busy, 0);

    // R8: idle with no request keeps strobes high
    repeat (20) @(negedge clk);
    check("R8 idle strobes", {ras_n, cas_n}, 3);

    // R6: request latency
    burst_len = 8'd5;
    ras_falls = 0;
    done_cnt = 0;
    force_req = 1'b1;
    @(negedge clk);
    force_req = 1'b0;
    check("R6 due set after one edge", refresh_due, 1);
    check("R6 cas still high", cas_n, 1);
    @(negedge clk);
    check("R6 cas low on next edge", cas_n, 0);
    check("R6 due cleared at start", refresh_due, 0);
    check("R2 ras high in lead", ras_n, 1);
    wait_quiet();
    check("R4 burst of 5", ras_falls, 5);

    // R4: length variants
    run_burst(1, "R4 burst of 1", 1);
    run_burst(0, "R4 zero means 256", 256);
    run_burst(200, "R4 burst of 200", 200);

    // R4: change during burst has no effect
    burst_len = 8'd4;
    @(negedge clk);
    ras_falls = 0;
    pulse_req();
    repeat (3) @(negedge clk);
    burst_len = 8'd200;
    wait_quiet();
    check("R4 captured length", ras_falls, 4);

    // R6: requests during a burst merge into one more burst
    burst_len = 8'd6;
    @(negedge clk);
    ras_falls = 0;
    done_cnt = 0;
    pulse_req();
    repeat (4) @(negedge clk);
    pulse_req();
    repeat (3) @(negedge clk);
    pulse_req();
    pulse_req();
    wait_quiet();
    check("R6 merged bursts", done_cnt, 2);
    check("R6 merged cycle total", ras_falls, 12);

    // R5: timer period with short bursts
    burst_len = 8'd2;
    busy_rises = 0;
    timer_en = 1'b1;
    while (busy_rises < 3) @(negedge clk);
    check("R5 start-to-start period", last_rise - prev_rise, INTERVAL);
    timer_en = 1'b0;
    wait_quiet();
    busy_rises = 0;
    repeat (2 * INTERVAL) @(negedge clk);
    check("R5 timer off gives no bursts", busy_rises, 0);

    // R6: timer faster than 256-cycle bursts -> back-to-back service
    burst_len = 8'd0;
    done_cnt = 0;
    timer_en = 1'b1;
    while (done_cnt < 2) @(negedge clk);
    timer_en = 1'b0;
    wait_quiet();
    check("R6 latched tick served", done_cnt >= 2, 1);

    finish_run();
  end

endmodule